// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Atomic Byte Access

The block is a 16-bit up-counter that software reaches over an 8-bit register bus. The count is split into a low byte and a high byte. Counting is driven by an external clock-enable tick. The tick passes through a selectable divider, and counting is gated by a run bit. When the count wraps from all ones to zero, a sticky overflow flag is set. The interrupt request is that flag masked by an enable bit.

Reading or writing a 16-bit count one byte at a time can tear if the count carries between the two accesses. An optional atomic mode avoids this by sending the high-byte address to a holding buffer:
- A low-byte read captures the live high byte into the buffer in the same access.
- A low-byte write loads the low byte from the bus and the high byte from the buffer in one cycle.

A separate synchronous clear request from outside zeroes the count and the divider without raising the flag.

Top module: `tick_timer16`

Register addresses (2-bit `bus_addr`):
- 0: count low byte.
- 1: count high byte. This is the buffer in atomic mode.
- 2: control. Bit 0 is run, bits 2:1 select the divider, bit 3 is atomic mode, bit 4 is interrupt enable, and bits 7:5 are stored and read back.
- 3: status. Bit 0 is the overflow flag.

Bus writes take effect at the clock edge of the write strobe. `bus_rdata` shows the addressed register combinationally.

## Requirements
- R1: With run set, the count advances by exactly one per divided tick, and from 0xFFFF it wraps to 0x0000.
- R2: The wrap from 0xFFFF to 0x0000 sets the status flag (bit 0, address 3), and the flag stays set until a write of 0 to that bit. Writing 1 has no effect. An overflow in the same cycle as a clearing write leaves the flag set.
- R3: `irq` is high exactly when the overflow flag and the interrupt enable (control bit 4) are both set.
- R4: Control bits 2:1 select the divider. Value 0 advances on every tick, 1 on every 2nd tick, 2 on every 4th tick and 3 on every 8th tick, counted from the last divider clear.
- R5: With run (control bit 0) clear, ticks do not change the count. Register writes still take effect.
- R6: With atomic mode (control bit 3) clear, address 1 reads and writes the live high byte of the count directly.
- R7: With atomic mode set, a read of address 0 copies the live high byte into the buffer in that access, and address 1 reads the buffer.
- R8: With atomic mode set, a write to address 1 changes only the buffer and never the live high byte. A write to address 0 loads the bus byte as the low byte and the buffer as the high byte, in the same cycle.
- R9: Any write to address 0 clears the divider. A write to address 1 never clears it.
- R10: A pulse on `cnt_clr` zeroes the count and the divider and does not set the overflow flag. A count write in the same cycle takes precedence over the clear.
- R11: After reset, the count, control register, buffer and flag are all zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Clock-enable tick that feeds the divider |
| cnt_clr | input | 1 | Synchronous request to zero count and divider |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, which has a side effect on address 0 in atomic mode |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data of the addressed register |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a low-byte read in atomic mode that lands on the very tick where the low byte carries into the high byte. The captured high byte must belong to the pre-carry value, while the live count moves on. The bench reaches it by loading 0x12FF and then issuing the low-byte read with `tick_en` high in the same cycle. It then reads the buffer and later the live high byte to show the two differ by one. Other cases are forced the same way by lining up strobes within a single cycle:
- A flag clear that coincides with a wrap.
- A divider that is part-way through its period when a byte write or `cnt_clr` arrives.

// File: rtl/tick_timer_pkg.sv
// Package: shared register address codes and control-field positions for
// the prescaled 16-bit timer. Assumes a 2-bit register address.
package tick_timer_pkg;

    typedef enum logic [1:0] {
        ADR_CNT_LO = 2'd0,
        ADR_CNT_HI = 2'd1,
        ADR_CTRL   = 2'd2,
        ADR_STAT   = 2'd3
    } tmr_addr_e;

    // control register field positions
    localparam int CTL_RUN    = 0;
    localparam int CTL_SEL_LO = 1;
    localparam int CTL_WIDE   = 3;
    localparam int CTL_IE     = 4;

    // status register field position
    localparam int STS_OVF    = 0;

endpackage

// File: rtl/tick_prescale.sv
// Module: tick divider. Counts qualified ticks and emits an advance pulse
// every 2**sel ticks since the last clear.
// Assumes: sel < 2**SEL_W, clr has priority over counting.
module tick_prescale #(
    parameter int SEL_W = 2,
    localparam int PS_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    output logic             adv
);

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;
    logic            step;

    // build a mask of the low `sel` bits of the divider
    always_comb begin
        for (int i = 0; i < PS_W; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    assign step = tick && run;
    assign adv  = step && !clr && ((ps_q & mask) == mask);

    // divider state: cleared on request, else steps on each qualified tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (clr) begin
            ps_q <= '0;
        end else if (step) begin
            ps_q <= ps_q + 1'b1;
        end
    end

    AST_PS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ps_q == '0)); // R9

    AST_PS_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(ps_q)); // R5

endmodule

// File: rtl/tick_count.sv
// Module: 16-bit count register with byte loads, synchronous clear and
// increment. Produces a one-cycle overflow pulse on an unloaded wrap.
// Assumes: at most one of ld_lo / ld_hi per cycle; loads beat clear,
// clear beats increment.
module tick_count #(
    parameter int BUS_W = 8,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [BUS_W-1:0] lo_val,
    input  logic [BUS_W-1:0] hi_src,
    input  logic [BUS_W-1:0] hi_val,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic any_ld;

    assign any_ld = ld_lo || ld_hi;
    assign ovf    = adv && (&cnt) && !any_ld && !clr;

    // count register with load > clear > increment priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld_lo) begin
            cnt <= {hi_src, lo_val};
        end else if (ld_hi) begin
            cnt[CNT_W-1:BUS_W] <= hi_val;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !any_ld && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R1

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !any_ld) |=> (cnt == '0)); // R10

    AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (cnt == {$past(hi_src), $past(lo_val)})); // R8

endmodule

// File: rtl/tick_regs.sv
// Module: software-visible registers of the timer: control, high-byte
// buffer, sticky overflow flag, address decode and read mux.
// Assumes: bus_rd and bus_wr are not both asserted to the same address.
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int SEL_W = 2,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ovf,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             run,
    output logic [SEL_W-1:0] sel,
    output logic             wide,
    output logic             lo_wr,
    output logic             hi_live_wr,
    output logic [BUS_W-1:0] hi_src,
    output logic             flag,
    output logic             irq
);

    logic [BUS_W-1:0] ctl_q;
    logic [BUS_W-1:0] buf_q;
    logic             ie;
    logic             hi_wr;
    logic             ctl_wr;
    logic             sts_clr;
    logic             lo_rd;
    logic [BUS_W-1:0] live_hi;

    assign live_hi = cnt[CNT_W-1:BUS_W];
    assign run     = ctl_q[CTL_RUN];
    assign sel     = ctl_q[CTL_SEL_LO +: SEL_W];
    assign wide    = ctl_q[CTL_WIDE];
    assign ie      = ctl_q[CTL_IE];

    // address decode of the strobes
    always_comb begin
        lo_wr   = bus_wr && (bus_addr == ADR_CNT_LO);
        hi_wr   = bus_wr && (bus_addr == ADR_CNT_HI);
        ctl_wr  = bus_wr && (bus_addr == ADR_CTRL);
        sts_clr = bus_wr && (bus_addr == ADR_STAT) && !bus_wdata[STS_OVF];
        lo_rd   = bus_rd && (bus_addr == ADR_CNT_LO);
    end

    assign hi_live_wr = hi_wr && !wide;
    assign hi_src     = wide ? buf_q : live_hi;
    assign irq        = flag && ie;

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= bus_wdata;
        end
    end

    // high-byte buffer: written from the bus or snapshotted on a low read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (hi_wr && wide) begin
            buf_q <= bus_wdata;
        end else if (lo_rd && wide) begin
            buf_q <= live_hi;
        end
    end

    // sticky overflow flag: set wins over a software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (ovf) begin
            flag <= 1'b1;
        end else if (sts_clr) begin
            flag <= 1'b0;
        end
    end

    // read mux of the addressed register
    always_comb begin
        unique case (tmr_addr_e'(bus_addr))
            ADR_CNT_LO: bus_rdata = cnt[BUS_W-1:0];
            ADR_CNT_HI: bus_rdata = wide ? buf_q : live_hi;
            ADR_CTRL:   bus_rdata = ctl_q;
            ADR_STAT:   bus_rdata = BUS_W'(flag);
            default:    bus_rdata = '0;
        endcase
    end

    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt == '0)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !sts_clr) |=> flag); // R2

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq); // R3

    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && lo_rd && !hi_wr) |=> (buf_q == $past(live_hi))); // R7

endmodule

// File: rtl/tick_timer16.sv
// Module: top of the prescaled 16-bit timer with atomic byte access.
// Wires the register block, the tick divider and the count register.
// Assumes: synchronous active-low reset; bus strobes are single-cycle.
module tick_timer16 #(
    parameter int BUS_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_clr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bus_rd,
    input  logic             bus_wr,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             ovf_flag,
    output logic             irq
);

    localparam int CNT_W = 2 * BUS_W;

    logic [CNT_W-1:0] cnt;
    logic             ovf;
    logic             run;
    logic [SEL_W-1:0] sel;
    logic             wide;
    logic             lo_wr;
    logic             hi_live_wr;
    logic [BUS_W-1:0] hi_src;
    logic             adv;

    tick_regs #(.BUS_W(BUS_W), .SEL_W(SEL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .cnt        (cnt),
        .ovf        (ovf),
        .bus_rdata  (bus_rdata),
        .run        (run),
        .sel        (sel),
        .wide       (wide),
        .lo_wr      (lo_wr),
        .hi_live_wr (hi_live_wr),
        .hi_src     (hi_src),
        .flag       (ovf_flag),
        .irq        (irq)
    );

    tick_prescale #(.SEL_W(SEL_W)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .run   (run),
        .sel   (sel),
        .clr   (lo_wr || cnt_clr),
        .adv   (adv)
    );

    tick_count #(.BUS_W(BUS_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .ld_lo  (lo_wr),
        .ld_hi  (hi_live_wr),
        .lo_val (bus_wdata),
        .hi_src (hi_src),
        .hi_val (bus_wdata),
        .clr    (cnt_clr),
        .cnt    (cnt),
        .ovf    (ovf)
    );

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr && !cnt_clr) |=> $stable(cnt)); // R5

    AST_WIDE_HI_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && bus_wr && (bus_addr == 2'd1) && !adv && !cnt_clr)
        |=> $stable(cnt[CNT_W-1:BUS_W])); // R8

endmodule

// File: tb/sim_tick_timer16.sv
// Bench: sweeps divider settings, wrap positions and atomic-mode byte
// access; expected values are computed arithmetically here.
module sim_tick_timer16;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       cnt_clr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic       ovf_flag;
    logic       irq;

    int total = 0;
    int bad = 0;

    tick_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_clr(cnt_clr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic get_cnt(output int v);
        logic [7:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [15:0] v);
        wr(2'd1, v[15:8]);
        wr(2'd0, v[7:0]);
    endtask

    initial begin
        #(CLK_P * 200000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk($sformatf("R11 reg %0d after reset", a), d, 0);
        end
        chk("R11 irq after reset", irq, 0);

        // R4 / R1 divider sweep
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n < 20; n++) begin
                wr(2'd2, 8'(1 | (s << 1)));
                load(16'h0000);
                ticks(n);
                get_cnt(v);
                chk($sformatf("R4 sel=%0d ticks=%0d", s, n), v, n >> s);
            end
        end

        // R1 / R2 wrap sweep
        wr(2'd2, 8'h01);
        for (int k = 0; k < 20; k++) begin
            load(16'hFFF8);
            wr(2'd3, 8'h00);
            ticks(k);
            get_cnt(v);
            chk($sformatf("R1 wrap k=%0d", k), v, (16'hFFF8 + k) & 16'hFFFF);
            chk($sformatf("R2 flag k=%0d", k), ovf_flag, (k >= 8) ? 1 : 0);
        end

        // R2 write 1 keeps flag, write 0 clears; R3 irq masking
        wr(2'd3, 8'h01);
        rd(2'd3, d);
        chk("R2 write 1 no effect", d, 1);
        chk("R3 irq masked", irq, 0);
        wr(2'd2, 8'h11);
        chk("R3 irq raised", irq, 1);
        wr(2'd3, 8'h00);
        rd(2'd3, d);
        chk("R2 write 0 clears", d, 0);
        chk("R3 irq follows flag", irq, 0);

        // R2 overflow coincides with clear
        wr(2'd2, 8'h01);
        load(16'hFFFF);
        bus_addr = 2'd3; bus_wdata = 8'h00; bus_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        chk("R2 overflow beats clear", ovf_flag, 1);
        get_cnt(v);
        chk("R1 wrapped to zero", v, 0);
        wr(2'd3, 8'h00);

        // R5 stopped timer
        wr(2'd2, 8'h00);
        load(16'h0100);
        ticks(10);
        get_cnt(v);
        chk("R5 stopped, writes applied", v, 16'h0100);

        // R6 live high byte in byte mode
        wr(2'd1, 8'h5A);
        rd(2'd1, d);
        chk("R6 live hi read", d, 8'h5A);
        rd(2'd0, d);
        chk("R6 low unchanged", d, 8'h00);

        // R7 snapshot across a carry
        wr(2'd2, 8'h09);
        load(16'h12FF);
        wr(2'd2, 8'h09);
        bus_addr = 2'd0; bus_rd = 1'b1; tick_en = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; tick_en = 1'b0;
        chk("R7 low at snapshot", d, 8'hFF);
        rd(2'd1, d);
        chk("R7 buffer holds pre-carry hi", d, 8'h12);
        wr(2'd2, 8'h01);
        get_cnt(v);
        chk("R7 live count advanced", v, 16'h1300);

        // R8 wide-mode high write isolated, low write commits
        wr(2'd2, 8'h08);
        wr(2'd1, 8'hAB);
        rd(2'd1, d);
        chk("R7 hi address reads buffer", d, 8'hAB);
        wr(2'd2, 8'h00);
        rd(2'd1, d);
        chk("R8 live hi untouched", d, 8'h13);
        wr(2'd2, 8'h08);
        wr(2'd1, 8'hAB);
        wr(2'd0, 8'hCD);
        wr(2'd2, 8'h00);
        get_cnt(v);
        chk("R8 atomic commit", v, 16'hABCD);

        // R9 divider clear rules, sel=3
        wr(2'd2, 8'h07);
        load(16'h0000);
        ticks(5);
        wr(2'd1, 8'h00);
        ticks(3);
        get_cnt(v);
        chk("R9 hi write keeps divider", v, 1);
        ticks(5);
        wr(2'd0, 8'h00);
        ticks(3);
        get_cnt(v);
        chk("R9 lo write clears divider", v, 0);
        ticks(5);
        get_cnt(v);
        chk("R9 full period after clear", v, 1);

        // R10 external clear
        wr(2'd2, 8'h00);
        load(16'h4321);
        cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
        get_cnt(v);
        chk("R10 clear zeroes count", v, 0);
        chk("R10 clear no flag", ovf_flag, 0);
        load(16'h4321);
        bus_addr = 2'd0; bus_wdata = 8'h77; bus_wr = 1'b1; cnt_clr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cnt_clr = 1'b0;
        get_cnt(v);
        chk("R10 write beats clear", v, 16'h4377);
        wr(2'd2, 8'h07);
        load(16'h0000);
        ticks(5);
        cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
        ticks(3);
        get_cnt(v);
        chk("R10 clear resets divider", v, 0);
        ticks(5);
        get_cnt(v);
        chk("R10 period after clear", v, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule